// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This unit sits between the register file of a 32-bit load/store processor and a synchronous data memory port. For each memory operation it adds a sign-extended 16-bit byte offset to a base register value to form the byte address. For a store it places the store data on the right byte lanes and raises only the byte enables that the access covers. For a load it takes the returned memory word, selects the addressed byte or halfword and extends it to full width, with or without sign, for the register file.

Three access sizes are handled: byte, halfword and full word. Lanes are little-endian, so address bits [1:0] name the lane. A halfword at an odd address, or a word whose two low address bits are not zero, raises an alignment fault and issues no memory access. Memory reads take one cycle, so the extended load result appears on the cycle after the request.

Top module: `mem_access_unit`

## Requirements
- R1: `memAddr` equals `baseVal` plus `offsetImm` sign-extended to 32 bits, modulo 2^32, in bytes. A base of zero therefore addresses directly from the offset, and an offset of zero addresses through the base alone.
- R2: The `opKind` encoding is 0 = idle, 1 = load word, 2 = load half signed, 3 = load half unsigned, 4 = load byte signed, 5 = load byte unsigned, 9 = store word, 10 = store half, 12 = store byte. Any other code, or `opValid` low, asserts neither `memRe` nor `memWe`. A valid, aligned load asserts only `memRe`. A valid, aligned store asserts only `memWe`.
- R3: During a store, `memByteEn` bit k covers data bits [8k+7:8k]. A byte store enables only bit `memAddr[1:0]`. A halfword store enables 4'b0011 at address offset 0 or 4'b1100 at offset 2. A word store enables 4'b1111. `memByteEn` is 0 whenever `memWe` is low.
- R4: `memWdata` carries the store byte repeated on all four lanes for a byte store, and the store halfword repeated on both halves for a halfword store. For a word store it carries the store data unchanged.
- R5: The load result takes the byte at lane `memAddr[1:0]`, or the halfword at lane pair `memAddr[1]`, from `memRdata`. Load byte signed and load half signed fill the upper bits with the top bit of the selected field. The unsigned variants fill them with zeros. Load word returns the whole word.
- R6: `alignFault` is high in the cycle of a valid word access with `memAddr[1:0]` not 0, or a valid halfword access with `memAddr[0]` set. A faulting access asserts neither `memWe` nor `memRe`, and memory contents are unchanged.
- R7: `loadValid` is high exactly in the cycle after a cycle in which `memRe` was high. `loadResult` is valid in that cycle and is zero whenever `loadValid` is low.
- R8: While `rstN` is low and after its release, `loadValid` is low and `loadResult` is zero until a load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 4 | Operation code (see R2) |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed byte offset |
| storeData | input | 32 | Register value to store |
| memAddr | output | 32 | Byte address to memory |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write request |
| memByteEn | output | 4 | Per-byte write enables |
| memWdata | output | 32 | Lane-steered write data |
| memRdata | input | 32 | Read data, one cycle after `memRe` |
| loadResult | output | 32 | Extended load value for the register file |
| loadValid | output | 1 | `loadResult` is valid |
| alignFault | output | 1 | Misaligned access detected |

## Verification
The bench builds the unit with its default widths: a 32-bit data path, a 16-bit offset and four byte lanes. These widths let a small offset reach every lane and both halfword positions. They also let a negative offset make the address wrap below zero. With them the bench can check sign and zero extension on values whose top bit is set and clear. Because each misaligned store is followed by a read-back, a write that should have been suppressed but leaked shows up in the loaded data.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     rdEn;
    logic     wrEn;
    accSize_e size;
    logic     sgnExt;
  } mauStrobe_t;

  localparam logic [3:0] OP_IDLE = 4'd0;
  localparam logic [3:0] OP_LW   = 4'd1;
  localparam logic [3:0] OP_LH   = 4'd2;
  localparam logic [3:0] OP_LHU  = 4'd3;
  localparam logic [3:0] OP_LB   = 4'd4;
  localparam logic [3:0] OP_LBU  = 4'd5;
  localparam logic [3:0] OP_SW   = 4'd9;
  localparam logic [3:0] OP_SH   = 4'd10;
  localparam logic [3:0] OP_SB   = 4'd12;

endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [3:0]           opKind,
  input  logic [LANE_BITS-1:0] addrLow,
  output mauStrobe_t           reqStb,
  output mauStrobe_t           rspStb,
  output logic [LANE_BITS-1:0] rspLane,
  output logic                 loadValid,
  output logic                 alignFault
);

  logic     isLoad, isStore, sgn;
  accSize_e size;

  always_comb begin
    isLoad  = 1'b0;
    isStore = 1'b0;
    sgn     = 1'b0;
    size    = SZ_WORD;
    unique case (opKind)
      OP_LW:   begin isLoad = 1'b1;  size = SZ_WORD; end
      OP_LH:   begin isLoad = 1'b1;  size = SZ_HALF; sgn = 1'b1; end
      OP_LHU:  begin isLoad = 1'b1;  size = SZ_HALF; end
      OP_LB:   begin isLoad = 1'b1;  size = SZ_BYTE; sgn = 1'b1; end
      OP_LBU:  begin isLoad = 1'b1;  size = SZ_BYTE; end
      OP_SW:   begin isStore = 1'b1; size = SZ_WORD; end
      OP_SH:   begin isStore = 1'b1; size = SZ_HALF; end
      OP_SB:   begin isStore = 1'b1; size = SZ_BYTE; end
      default: ;
    endcase
  end

  logic misaligned;
  always_comb begin
    unique case (size)
      SZ_WORD: misaligned = (addrLow != '0);
      SZ_HALF: misaligned = addrLow[0];
      default: misaligned = 1'b0;
    endcase
  end

  assign alignFault = opValid && (isLoad || isStore) && misaligned;

  always_comb begin
    reqStb.rdEn   = opValid && isLoad  && !misaligned;
    reqStb.wrEn   = opValid && isStore && !misaligned;
    reqStb.size   = size;
    reqStb.sgnExt = sgn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      rspStb    <= '0;
      rspLane   <= '0;
    end else begin
      loadValid <= reqStb.rdEn;
      if (reqStb.rdEn) begin
        rspStb  <= reqStb;
        rspLane <= addrLow;
      end
    end
  end

endmodule

// File: rtl/mau_datapath.sv
module mau_datapath
  import mau_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFFS_W    = 16,
  parameter int LANES     = DATA_W / 8,
  parameter int LANE_BITS = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]    baseVal,
  input  logic [OFFS_W-1:0]    offsetImm,
  input  logic [DATA_W-1:0]    storeData,
  input  logic [DATA_W-1:0]    memRdata,
  input  mauStrobe_t           reqStb,
  input  mauStrobe_t           rspStb,
  input  logic [LANE_BITS-1:0] rspLane,
  input  logic                 loadValid,
  output logic [DATA_W-1:0]    effAddr,
  output logic [LANE_BITS-1:0] addrLow,
  output logic [LANES-1:0]     byteEn,
  output logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    loadResult
);

  localparam int SHIFT_W = LANE_BITS + 3;

  assign effAddr = baseVal + {{(DATA_W-OFFS_W){offsetImm[OFFS_W-1]}}, offsetImm};
  assign addrLow = effAddr[LANE_BITS-1:0];

  // Per-lane write enables
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    always_comb begin
      unique case (reqStb.size)
        SZ_BYTE: hit = (addrLow == LANE_BITS'(i));
        SZ_HALF: hit = ((addrLow >> 1) == LANE_BITS'(i >> 1));
        default: hit = 1'b1;
      endcase
    end
    assign byteEn[i] = reqStb.wrEn && hit;
  end

  always_comb begin
    unique case (reqStb.size)
      SZ_BYTE: wrData = {LANES{storeData[7:0]}};
      SZ_HALF: wrData = {(LANES/2){storeData[15:0]}};
      default: wrData = storeData;
    endcase
  end

  logic [DATA_W-1:0] shifted;
  assign shifted = memRdata >> {rspLane, 3'b000};

  always_comb begin
    unique case (rspStb.size)
      SZ_BYTE: loadResult = {{(DATA_W-8){rspStb.sgnExt && shifted[7]}}, shifted[7:0]};
      SZ_HALF: loadResult = {{(DATA_W-16){rspStb.sgnExt && shifted[15]}}, shifted[15:0]};
      default: loadResult = memRdata;
    endcase
    if (!loadValid) loadResult = '0;
  end

  logic [SHIFT_W-1:0] unusedShift;
  assign unusedShift = '0;

endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFFS_W-1:0] offsetImm,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] loadResult,
  output logic              loadValid,
  output logic              alignFault
);

  localparam int LANE_BITS = $clog2(LANES);

  mauStrobe_t           reqStb, rspStb;
  logic [LANE_BITS-1:0] addrLow, rspLane;

  mau_ctrl #(.LANE_BITS(LANE_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .addrLow(addrLow), .reqStb(reqStb), .rspStb(rspStb),
    .rspLane(rspLane), .loadValid(loadValid), .alignFault(alignFault)
  );

  mau_datapath #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .LANES(LANES),
                 .LANE_BITS(LANE_BITS)) dp_i (
    .baseVal(baseVal), .offsetImm(offsetImm), .storeData(storeData),
    .memRdata(memRdata), .reqStb(reqStb), .rspStb(rspStb),
    .rspLane(rspLane), .loadValid(loadValid), .effAddr(memAddr),
    .addrLow(addrLow), .byteEn(memByteEn), .wrData(memWdata),
    .loadResult(loadResult)
  );

  assign memRe = reqStb.rdEn;
  assign memWe = reqStb.wrEn;

endmodule

// File: rtl/mau_checks.sv
module mau_checks
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opKind,
  input logic              memRe,
  input logic              memWe,
  input logic [LANES-1:0]  memByteEn,
  input logic [DATA_W-1:0] loadResult,
  input logic              loadValid,
  input logic              alignFault
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!memRe && !memWe));

  p_rd_wr_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  p_enables_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
               $countones(memByteEn) == LANES));

  p_no_enable_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> (memByteEn == '0));

  p_byte_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && opKind == OP_LB) |=> (loadResult[DATA_W-1:8] == {(DATA_W-8){loadResult[7]}}));

  p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && opKind == OP_LBU) |=> (loadResult[DATA_W-1:8] == '0));

  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!memWe && !memRe && memByteEn == '0));

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> loadValid);

  p_valid_only_after_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memRe |=> !loadValid);

  p_result_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (loadResult == '0));

endmodule

bind mem_access_unit mau_checks #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
  .memRe(memRe), .memWe(memWe), .memByteEn(memByteEn),
  .loadResult(loadResult), .loadValid(loadValid), .alignFault(alignFault)
);

// File: tb/mem_access_unit_tb_top.sv
module mem_access_unit_tb_top;
  import mau_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opKind = OP_IDLE;
  logic [31:0] baseVal = '0;
  logic [15:0] offsetImm = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memAddr, memWdata, loadResult;
  logic [31:0] memRdata = '0;
  logic        memRe, memWe, loadValid, alignFault;
  logic [3:0]  memByteEn;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  mem_access_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .baseVal(baseVal), .offsetImm(offsetImm), .storeData(storeData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memByteEn(memByteEn), .memWdata(memWdata), .memRdata(memRdata),
    .loadResult(loadResult), .loadValid(loadValid), .alignFault(alignFault)
  );

  // Simple synchronous memory, word index from address bits [5:2]
  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[5:2]];
    if (memWe)
      for (int b = 0; b < 4; b++)
        if (memByteEn[b]) mem[memAddr[5:2]][8*b +: 8] <= memWdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic [3:0] kind, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] data,
                         input logic [31:0] expAddr, input logic [3:0] expBe,
                         input logic [31:0] expWd, input bit expFault);
    @(negedge clk);
    opValid = 1'b1; opKind = kind; baseVal = base; offsetImm = off; storeData = data;
    #1;
    check(memAddr == expAddr, "R1 address", memAddr, expAddr);
    check(alignFault == expFault, "R6 fault flag", 32'(alignFault), 32'(expFault));
    check(memWe == !expFault && !memRe, "R2 write strobe", 32'(memWe), 32'(!expFault));
    check(memByteEn == expBe, "R3 byte enables", 32'(memByteEn), 32'(expBe));
    if (!expFault) check(memWdata == expWd, "R4 write data", memWdata, expWd);
    @(negedge clk);
    opValid = 1'b0; opKind = OP_IDLE;
  endtask

  task automatic doLoad(input logic [3:0] kind, input logic [31:0] base,
                        input logic [15:0] off, input logic [31:0] expVal,
                        input bit expFault, input string req);
    @(negedge clk);
    opValid = 1'b1; opKind = kind; baseVal = base; offsetImm = off;
    #1;
    check(alignFault == expFault, "R6 fault flag", 32'(alignFault), 32'(expFault));
    check(memRe == !expFault && !memWe, "R2 read strobe", 32'(memRe), 32'(!expFault));
    @(negedge clk);
    opValid = 1'b0; opKind = OP_IDLE;
    check(loadValid == !expFault, "R7 load valid", 32'(loadValid), 32'(!expFault));
    check(loadResult == (expFault ? 32'h0 : expVal), req, loadResult, expVal);
  endtask

  task automatic testReset();
    check(loadValid == 1'b0, "R8 reset valid", 32'(loadValid), 32'h0);
    check(loadResult == 32'h0, "R8 reset result", loadResult, 32'h0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    opValid = 1'b0; opKind = OP_SW; baseVal = 32'h100;
    #1;
    check(!memWe && !memRe, "R2 idle no access", {memRe, memWe}, 32'h0);
    opValid = 1'b1; opKind = 4'd7;
    #1;
    check(!memWe && !memRe && memByteEn == 0, "R2 unused code", {memRe, memWe}, 32'h0);
    @(negedge clk);
    opValid = 1'b0; opKind = OP_IDLE;
    check(loadValid == 1'b0, "R7 no valid after idle", 32'(loadValid), 32'h0);
  endtask

  task automatic testWordPath();
    doStore(OP_SW, 32'h100, 16'h0000, 32'h11223344, 32'h100, 4'b1111, 32'h11223344, 1'b0);
    doLoad(OP_LW, 32'h0, 16'h0100, 32'h11223344, 1'b0, "R5 load word direct");
  endtask

  task automatic testBytePath();
    doStore(OP_SB, 32'h104, 16'hFFFF, 32'h000000A5, 32'h103, 4'b1000, 32'hA5A5A5A5, 1'b0);
    doLoad(OP_LB,  32'h103, 16'h0, 32'hFFFFFFA5, 1'b0, "R5 load byte signed");
    doLoad(OP_LBU, 32'h103, 16'h0, 32'h000000A5, 1'b0, "R5 load byte unsigned");
    doLoad(OP_LB,  32'h100, 16'h0, 32'h00000044, 1'b0, "R5 load byte positive");
    doStore(OP_SB, 32'h0, 16'h0101, 32'hFFFFFF7E, 32'h101, 4'b0010, 32'h7E7E7E7E, 1'b0);
    doLoad(OP_LW,  32'h100, 16'h0, 32'hA522_7E44, 1'b0, "R3 byte lanes untouched");
  endtask

  task automatic testHalfPath();
    doStore(OP_SH, 32'h0, 16'h0102, 32'hCAFE8001, 32'h102, 4'b1100, 32'h80018001, 1'b0);
    doLoad(OP_LH,  32'h102, 16'h0, 32'hFFFF8001, 1'b0, "R5 load half signed");
    doLoad(OP_LHU, 32'h102, 16'h0, 32'h00008001, 1'b0, "R5 load half unsigned");
    doStore(OP_SH, 32'h100, 16'h0, 32'h00001234, 32'h100, 4'b0011, 32'h12341234, 1'b0);
    doLoad(OP_LH,  32'h100, 16'h0, 32'h00001234, 1'b0, "R5 load half low lane");
    doLoad(OP_LW,  32'h100, 16'h0, 32'h80011234, 1'b0, "R3 half lanes");
  endtask

  task automatic testMisaligned();
    doStore(OP_SW, 32'h102, 16'h0, 32'hDEADBEEF, 32'h102, 4'b0000, 32'h0, 1'b1);
    doStore(OP_SH, 32'h101, 16'h0, 32'hDEADBEEF, 32'h101, 4'b0000, 32'h0, 1'b1);
    doLoad(OP_LW,  32'h100, 16'h0, 32'h80011234, 1'b0, "R6 memory unchanged");
    doLoad(OP_LW,  32'h101, 16'h0, 32'h0, 1'b1, "R6 faulted word load");
    doLoad(OP_LHU, 32'h103, 16'h0, 32'h0, 1'b1, "R6 faulted half load");
    doLoad(OP_LBU, 32'h101, 16'h0, 32'h00000012, 1'b0, "R6 odd byte allowed");
  endtask

  task automatic testWrap();
    doStore(OP_SW, 32'h0, 16'hFFFC, 32'h0BADF00D, 32'hFFFFFFFC, 4'b1111, 32'h0BADF00D, 1'b0);
    doLoad(OP_LW, 32'h8, 16'hFFF4, 32'h0BADF00D, 1'b0, "R1 negative offset wraps");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdle();
    testWordPath();
    testBytePath();
    testHalfPath();
    testMisaligned();
    testWrap();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule